// File: doc/BRIEF.md
# External Bus Burst Access Sequencer

This block sits between an internal requester and an external memory bus. It turns one internal request into the sequence of external beats that carries it out. Each request has an address, a transfer size (byte, half-word, word or a 32-byte line) and a direction. It also says whether the address fell inside a chip-select region, and if so which one. Every region has three attribute bits: a 16-bit port width, a burst-inhibit bit and an 8-beat length bit. A global 16-bit bus mode narrows every access to half-word beats.

Line reads to a region whose burst-inhibit bit is clear go out as wrapping bursts of 4 or 8 beats. The burst starts at the requested word and wraps inside the block that the burst covers. Line writes, and line reads that may not burst, are broken into single transfers that walk up the line at the port width. Accesses outside any region always use a 32-bit, non-bursting port. The one exception is 16-bit bus mode, where a 32-bit access becomes a 2-beat burst so that it stays coherent.

Each beat is presented with its address, the half-words it carries, a burst marker, a last marker and the direction. The beat is held until it is acknowledged. A new request is taken only after the final beat is acknowledged.

Top module: `ext_burst_seq`

## Requirements
- R1: `req_ready` is high only when no sequence is in progress. A request taken on a rising edge presents its first beat from that edge on. Every beat holds all its fields steady until the edge at which `beat_ack` is high.
- R2: A line read (size code 3) to a region whose burst-inhibit bit is 0 is a wrapping burst with `beat_burst`=1. It has 4 beats, or 8 when the region's length bit is 1. The first beat is at the request address with its low bits cleared to the port width. Each following beat adds the port width in bytes, modulo (beats × port bytes), inside the aligned block of that size.
- R3: A line write to a region, or a line read to a region with burst inhibit set, is split into 32/P single beats (`beat_burst`=0), where P is the port width in bytes. The beats start at the 32-byte-aligned line base and rise by P.
- R4: The port width is 16 bits when the global 16-bit bus mode is set, or when the request hits a region whose width bit is 1. Otherwise it is 32 bits, and accesses outside all regions are always 32 bits outside 16-bit bus mode.
- R5: A word (size code 2) on a 16-bit port takes two beats: first at the word-aligned address with lane code 2'b10 (upper half), then at that address plus 2 with lane code 2'b01 (lower half).
- R6: A beat that is not inside a region bursts only in 16-bit bus mode, as part of a word or line that it breaks into 2-beat pairs. Such beats carry `beat_burst`=1. Writes to a region never burst.
- R7: Lane code 2'b11 marks a 32-bit beat, used for word and line on a 32-bit port, at a word-aligned address. A byte or half-word (size codes 0 and 1) is one single beat at the unmodified request address. Its lane code is 2'b10 when address bit 1 is 0 and 2'b01 when it is 1.
- R8: `beat_last` is high with the final beat of every sequence and with no other beat. `req_ready` returns high one cycle after that beat is acknowledged.
- R9: `beat_write` equals the direction of the request for every beat of its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus16_mode | input | 1 | Global 16-bit external bus mode |
| cfg_port16 | input | NCS | Per-region 16-bit port width |
| cfg_burst_inh | input | NCS | Per-region burst inhibit |
| cfg_blen8 | input | NCS | Per-region 8-beat burst length |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | Request is a write |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 line |
| req_addr | input | AW | Request byte address |
| req_cs_hit | input | 1 | Address matched a chip-select region |
| req_cs_idx | input | CSW | Index of the matched region |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | AW | Beat byte address |
| beat_lane | output | 2 | Half-words carried: 11 both, 10 upper, 01 lower |
| beat_burst | output | 1 | Beat belongs to a burst |
| beat_last | output | 1 | Final beat of the sequence |
| beat_write | output | 1 | Beat direction |
| beat_ack | input | 1 | Beat acknowledge |

## Verification
The bench sweeps every combination of region hit, bus mode, port width, inhibit, length, direction and size, at start offsets that include the middle and the end of a burst block. Each case is checked against addresses computed arithmetically in the bench.

A design that clears the wrong address bits before wrapping would start at the block base, or run past the block end, on the offsets that are not aligned. A design that reads the attributes of the wrong region is caught because the other regions always hold the opposite settings. Mixing up half-word order on a 16-bit port shows up as swapped lane codes. Letting writes or accesses outside all regions burst shows up as a wrong burst marker. Acknowledges come after varying delays, so a beat that advances without its acknowledge, or a last marker that comes one beat early, is also reported.

// File: rtl/ext_burst_seq_pkg.sv
package ext_burst_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    LANE_NONE  = 2'b00,
    LANE_LOWER = 2'b01,
    LANE_UPPER = 2'b10,
    LANE_BOTH  = 2'b11
  } lane_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/ext_burst_seq_plan.sv
// Combinational planner: turns a request plus region attributes into a
// sequence descriptor (base, start offset, wrap mask, step, beat count).
module ext_burst_seq_plan
  import ext_burst_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NCS        = 4,
  parameter int CSW        = 2,
  parameter int LINE_BYTES = 32,
  parameter int OW         = 5,
  parameter int CNTW       = 5
) (
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  input  logic            req_write,
  input  logic            req_cs_hit,
  input  logic [CSW-1:0]  req_cs_idx,
  input  logic            bus16_mode,
  input  logic [NCS-1:0]  cfg_port16,
  input  logic [NCS-1:0]  cfg_burst_inh,
  input  logic [NCS-1:0]  cfg_blen8,
  output logic [AW-1:0]   pl_base,
  output logic [OW-1:0]   pl_off0,
  output logic [OW-1:0]   pl_mask,
  output logic            pl_step16,
  output logic            pl_full,
  output logic            pl_burst,
  output logic [CNTW-1:0] pl_nbeats
);

  localparam logic [OW-1:0]   LINE_MASK   = OW'(LINE_BYTES - 1);
  localparam logic [CNTW-1:0] LINE_HALVES = CNTW'(LINE_BYTES / 2);
  localparam logic [CNTW-1:0] LINE_WORDS  = CNTW'(LINE_BYTES / 4);

  logic       rg_port16;
  logic       rg_inh;
  logic       rg_blen8;
  logic       eff16;
  logic       wrap_ok;
  logic [OW:0] blk_bytes;
  logic [OW-1:0] blk_mask;
  logic [OW-1:0] align_keep;
  xfer_size_e size;

  // Region attribute selection; non-chip-select defaults: 32-bit, inhibited, short
  always_comb begin
    rg_port16 = 1'b0;
    rg_inh    = 1'b1;
    rg_blen8  = 1'b0;
    for (int k = 0; k < NCS; k++) begin
      if (req_cs_hit && (req_cs_idx == CSW'(k))) begin
        rg_port16 = cfg_port16[k];
        rg_inh    = cfg_burst_inh[k];
        rg_blen8  = cfg_blen8[k];
      end
    end
  end

  always_comb begin
    size       = xfer_size_e'(req_size);
    eff16      = bus16_mode | rg_port16;
    wrap_ok    = req_cs_hit & ~rg_inh & ~req_write;
    // block = beats * port bytes = 2^(2+blen8) * 2^(port16 ? 1 : 2)
    blk_bytes  = (OW+1)'(1) << (3 + {2'b00, rg_blen8} + {2'b00, ~eff16});
    blk_mask   = OW'(blk_bytes - (OW+1)'(1));
    align_keep = eff16 ? ~OW'(1) : ~OW'(3);
  end

  always_comb begin
    pl_base   = req_addr;
    pl_off0   = '0;
    pl_mask   = '0;
    pl_step16 = eff16;
    pl_full   = 1'b0;
    pl_burst  = 1'b0;
    pl_nbeats = CNTW'(1);
    unique case (size)
      SZ_BYTE, SZ_HALF: begin
        pl_base   = req_addr;
        pl_nbeats = CNTW'(1);
      end
      SZ_WORD: begin
        pl_mask   = OW'(3);
        pl_base   = req_addr & ~AW'(3);
        pl_full   = ~eff16;
        pl_nbeats = eff16 ? CNTW'(2) : CNTW'(1);
        pl_burst  = eff16 & ~req_cs_hit;
      end
      SZ_LINE: begin
        pl_full = ~eff16;
        if (wrap_ok) begin
          pl_mask   = blk_mask;
          pl_base   = req_addr & ~AW'(blk_mask);
          pl_off0   = req_addr[OW-1:0] & blk_mask & align_keep;
          pl_nbeats = rg_blen8 ? CNTW'(8) : CNTW'(4);
          pl_burst  = 1'b1;
        end else begin
          pl_mask   = LINE_MASK;
          pl_base   = req_addr & ~AW'(LINE_MASK);
          pl_off0   = '0;
          pl_nbeats = eff16 ? LINE_HALVES : LINE_WORDS;
          pl_burst  = ~req_cs_hit & bus16_mode;
        end
      end
      default: begin
        pl_base = req_addr;
      end
    endcase
  end

endmodule

// File: rtl/ext_burst_seq_beat.sv
// Beat engine: holds the descriptor and steps through the beats on acknowledge.
module ext_burst_seq_beat
  import ext_burst_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OW   = 5,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            acc,
  input  logic [AW-1:0]   ld_base,
  input  logic [OW-1:0]   ld_off0,
  input  logic [OW-1:0]   ld_mask,
  input  logic            ld_step16,
  input  logic            ld_full,
  input  logic            ld_burst,
  input  logic            ld_write,
  input  logic            ld_cs,
  input  logic [CNTW-1:0] ld_nbeats,
  input  logic            beat_ack,
  output logic            busy,
  output logic [AW-1:0]   beat_addr,
  output logic [1:0]      beat_lane,
  output logic            beat_burst,
  output logic            beat_last,
  output logic            beat_write
);

  seq_state_e    state_q, state_d;
  logic [CNTW-1:0] idx_q, idx_d;
  logic [OW-1:0] off_q, off_d;
  logic [AW-1:0] base_q;
  logic [OW-1:0] mask_q;
  logic          step16_q;
  logic          full_q;
  logic          burst_q;
  logic          write_q;
  logic          cs_q;
  logic [CNTW-1:0] nbeats_q;
  logic          cfg_en;
  logic          adv;
  lane_e         lane;

  assign cfg_en = acc & (state_q == SEQ_IDLE);
  assign adv    = (state_q == SEQ_RUN) & beat_ack;

  always_comb begin
    beat_addr  = base_q | AW'(off_q & mask_q);
    beat_last  = (state_q == SEQ_RUN) & (idx_q == nbeats_q - CNTW'(1));
    busy       = (state_q == SEQ_RUN);
    beat_burst = burst_q & busy;
    beat_write = write_q & busy;
    if (!busy)          lane = LANE_NONE;
    else if (full_q)    lane = LANE_BOTH;
    else if (beat_addr[1]) lane = LANE_LOWER;
    else                lane = LANE_UPPER;
    beat_lane = lane;
  end

  // next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    off_d   = off_q;
    if (cfg_en) begin
      state_d = SEQ_RUN;
      idx_d   = '0;
      off_d   = ld_off0;
    end else if (adv) begin
      if (beat_last) begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + CNTW'(1);
        off_d = off_q + (step16_q ? OW'(2) : OW'(4));
      end
    end
  end

  // sequence registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      off_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      off_q   <= off_d;
    end
  end

  // descriptor registers, loaded under clock enable
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      mask_q   <= '0;
      step16_q <= 1'b0;
      full_q   <= 1'b0;
      burst_q  <= 1'b0;
      write_q  <= 1'b0;
      cs_q     <= 1'b0;
      nbeats_q <= CNTW'(1);
    end else if (cfg_en) begin
      base_q   <= ld_base;
      mask_q   <= ld_mask;
      step16_q <= ld_step16;
      full_q   <= ld_full;
      burst_q  <= ld_burst;
      write_q  <= ld_write;
      cs_q     <= ld_cs;
      nbeats_q <= ld_nbeats;
    end
  end

  assert_beat_hold_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && !beat_ack |=> busy && $stable(beat_addr) && $stable(beat_lane)
      && $stable(beat_burst) && $stable(beat_last));

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && beat_last && beat_ack |=> !busy);

  assert_cs_write_single_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && beat_write && beat_burst |-> !cs_q);

  assert_wide_aligned_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && (beat_lane == 2'b11) |-> (beat_addr[1:0] == 2'b00));

  assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> (idx_q < nbeats_q));

  assert_wrap_in_block_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && beat_ack && !beat_last |=> ((beat_addr & ~AW'(mask_q)) == base_q));

endmodule

// File: rtl/ext_burst_seq.sv
module ext_burst_seq #(
  parameter int AW         = 32,
  parameter int NCS        = 4,
  parameter int LINE_BYTES = 32,
  localparam int CSW       = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int OW        = $clog2(LINE_BYTES),
  localparam int CNTW      = $clog2(LINE_BYTES / 2 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus16_mode,
  input  logic [NCS-1:0] cfg_port16,
  input  logic [NCS-1:0] cfg_burst_inh,
  input  logic [NCS-1:0] cfg_blen8,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_size,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_cs_hit,
  input  logic [CSW-1:0] req_cs_idx,
  output logic           beat_valid,
  output logic [AW-1:0]  beat_addr,
  output logic [1:0]     beat_lane,
  output logic           beat_burst,
  output logic           beat_last,
  output logic           beat_write,
  input  logic           beat_ack
);

  logic rst_meta_q, rst_sync_q;
  logic busy;
  logic acc;
  logic [AW-1:0]   pl_base;
  logic [OW-1:0]   pl_off0;
  logic [OW-1:0]   pl_mask;
  logic            pl_step16;
  logic            pl_full;
  logic            pl_burst;
  logic [CNTW-1:0] pl_nbeats;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign req_ready  = rst_sync_q & ~busy;
  assign acc        = req_valid & req_ready;
  assign beat_valid = busy;

  ext_burst_seq_plan #(
    .AW(AW), .NCS(NCS), .CSW(CSW), .LINE_BYTES(LINE_BYTES), .OW(OW), .CNTW(CNTW)
  ) u_plan (
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_write    (req_write),
    .req_cs_hit   (req_cs_hit),
    .req_cs_idx   (req_cs_idx),
    .bus16_mode   (bus16_mode),
    .cfg_port16   (cfg_port16),
    .cfg_burst_inh(cfg_burst_inh),
    .cfg_blen8    (cfg_blen8),
    .pl_base      (pl_base),
    .pl_off0      (pl_off0),
    .pl_mask      (pl_mask),
    .pl_step16    (pl_step16),
    .pl_full      (pl_full),
    .pl_burst     (pl_burst),
    .pl_nbeats    (pl_nbeats)
  );

  ext_burst_seq_beat #(
    .AW(AW), .OW(OW), .CNTW(CNTW)
  ) u_beat (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .acc       (acc),
    .ld_base   (pl_base),
    .ld_off0   (pl_off0),
    .ld_mask   (pl_mask),
    .ld_step16 (pl_step16),
    .ld_full   (pl_full),
    .ld_burst  (pl_burst),
    .ld_write  (req_write),
    .ld_cs     (req_cs_hit),
    .ld_nbeats (pl_nbeats),
    .beat_ack  (beat_ack),
    .busy      (busy),
    .beat_addr (beat_addr),
    .beat_lane (beat_lane),
    .beat_burst(beat_burst),
    .beat_last (beat_last),
    .beat_write(beat_write)
  );

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc |=> beat_valid && !req_ready);

  assert_write_follows_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    acc |=> (beat_write == $past(req_write)));

endmodule

// File: tb/ext_burst_seq_bench.sv
module ext_burst_seq_bench;

  localparam int AW  = 32;
  localparam int NCS = 4;
  localparam int CSW = 2;
  localparam int LB  = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           bus16_mode;
  logic [NCS-1:0] cfg_port16, cfg_burst_inh, cfg_blen8;
  logic           req_valid, req_ready, req_write, req_cs_hit;
  logic [1:0]     req_size;
  logic [AW-1:0]  req_addr;
  logic [CSW-1:0] req_cs_idx;
  logic           beat_valid, beat_burst, beat_last, beat_write, beat_ack;
  logic [AW-1:0]  beat_addr;
  logic [1:0]     beat_lane;

  int n_chk = 0;
  int n_bad = 0;
  int wait_seed = 0;

  ext_burst_seq u_ext_burst_seq (
    .clk(clk), .rst_n(rst_n), .bus16_mode(bus16_mode),
    .cfg_port16(cfg_port16), .cfg_burst_inh(cfg_burst_inh), .cfg_blen8(cfg_blen8),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_cs_hit(req_cs_hit),
    .req_cs_idx(req_cs_idx), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_lane(beat_lane), .beat_burst(beat_burst), .beat_last(beat_last),
    .beat_write(beat_write), .beat_ack(beat_ack)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input bit cs, input bit b16, input bit p16, input bit inh,
                         input bit b8, input bit wr, input int sz,
                         input logic [AW-1:0] addr, input int ridx);
    int pb, n, blk, start, step;
    bit ebur, wide;
    logic [AW-1:0] base, ea;
    logic [1:0] el;
    string tag;
    bit pb16;
    pb16 = b16 || (cs && p16);
    pb   = pb16 ? 2 : 4;
    // defaults: single beat at request address
    n = 1; base = addr; blk = 1; start = 0; step = 0; ebur = 0; wide = 0; tag = "R7";
    if (sz == 2) begin
      base = addr & ~32'd3; blk = 4;
      if (pb16) begin n = 2; step = 2; ebur = !cs; tag = cs ? "R5" : "R6"; end
      else      begin n = 1; step = 4; wide = 1; tag = "R4"; end
    end else if (sz == 3) begin
      wide = (pb == 4); step = pb;
      if (cs && !inh && !wr) begin
        n = b8 ? 8 : 4; blk = n * pb;
        base = addr - (addr % blk);
        start = int'(addr % blk) - int'(addr % pb);
        ebur = 1; tag = "R2";
      end else begin
        n = LB / pb; blk = LB; base = addr - (addr % LB); start = 0;
        ebur = !cs && b16;
        tag = cs ? "R3" : "R6";
      end
      if (cs && p16 && !b16) tag = (tag == "R2") ? "R2" : "R4";
    end

    // other regions get the opposite attributes
    for (int k = 0; k < NCS; k++) begin
      cfg_port16[k]    = (k == ridx) ? p16 : !p16;
      cfg_burst_inh[k] = (k == ridx) ? inh : !inh;
      cfg_blen8[k]     = (k == ridx) ? b8  : !b8;
    end
    bus16_mode = b16;

    @(negedge clk);
    chk(req_ready === 1'b1 && beat_valid === 1'b0, "R1", "idle before request",
        {req_ready, beat_valid}, 2'b10);
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_addr = addr;
    req_cs_hit = cs; req_cs_idx = CSW'(ridx);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~addr;       // request fields must not matter after acceptance
    req_size  = ~2'(sz);

    for (int i = 0; i < n; i++) begin
      int wt;
      ea = base + AW'((start + i * step) % blk);
      el = wide ? 2'b11 : (ea[1] ? 2'b01 : 2'b10);
      chk(beat_valid === 1'b1 && req_ready === 1'b0, "R1", "beat presented, not ready",
          {beat_valid, req_ready}, 2'b10);
      chk(beat_addr === ea, tag, "beat address", beat_addr, ea);
      chk(beat_lane === el, (sz < 2) ? "R7" : tag, "lane code", beat_lane, el);
      chk(beat_burst === ebur, (cs && wr) ? "R6" : tag, "burst marker", beat_burst, ebur);
      chk(beat_last === (i == n - 1), "R8", "last marker", beat_last, (i == n - 1));
      chk(beat_write === wr, "R9", "direction", beat_write, wr);
      wt = wait_seed % 3;
      wait_seed++;
      for (int w = 0; w < wt; w++) begin
        @(negedge clk);
        chk(beat_valid === 1'b1 && beat_addr === ea && beat_lane === el, "R1",
            "beat held without acknowledge", beat_addr, ea);
      end
      beat_ack = 1'b1;
      @(negedge clk);
      beat_ack = 1'b0;
    end
    chk(req_ready === 1'b1 && beat_valid === 1'b0, "R8", "ready after last acknowledge",
        {req_ready, beat_valid}, 2'b10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int offs [5] = '{0, 2, 6, 14, 26};
    int cnt = 0;
    rst_n = 1'b0; bus16_mode = 1'b0;
    cfg_port16 = '0; cfg_burst_inh = '0; cfg_blen8 = '0;
    req_valid = 1'b0; req_write = 1'b0; req_size = '0; req_addr = '0;
    req_cs_hit = 1'b0; req_cs_idx = '0; beat_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(beat_valid === 1'b0 && req_ready === 1'b0, "R1", "in reset",
        {beat_valid, req_ready}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(beat_valid === 1'b0 && req_ready === 1'b1, "R1", "reset state",
        {beat_valid, req_ready}, 2'b01);

    for (int cs = 0; cs < 2; cs++)
      for (int b16 = 0; b16 < 2; b16++)
        for (int p16 = 0; p16 < 2; p16++)
          for (int inh = 0; inh < 2; inh++)
            for (int b8 = 0; b8 < 2; b8++)
              for (int wr = 0; wr < 2; wr++)
                for (int sz = 0; sz < 4; sz++)
                  for (int o = 0; o < 5; o++) begin
                    logic [AW-1:0] a;
                    a = 32'h0004_2000 + AW'(cnt % 3) * 32'h40 + AW'(offs[o]);
                    if (sz == 1 || sz == 3) a = a & ~32'd1;
                    run_one(cs[0], b16[0], p16[0], inh[0], b8[0], wr[0], sz, a, cnt % NCS);
                    cnt++;
                  end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule